// File: doc/BRIEF.md
# Scrolled Tile Background Pixel Fetcher

This block produces one background pixel per request for a tile-based video display. It is given a screen coordinate and the current scroll state. From these it works out which cell of the tile map lies under that pixel after scrolling, and reads the two-byte map entry from video memory. It then reads the four bit-plane bytes of the selected pattern row and returns a 4-bit colour index with the palette-select and priority flags of the entry.

Scrolling is not symmetric. The horizontal scroll value is taken away from the column, while the vertical scroll value is added to the line. Two lock flags can pin a region of the screen in place: the leftmost two tile columns against horizontal scroll, and the columns to the right of 191 against vertical scroll. The short display mode (192 lines) uses a map 28 rows tall that wraps at line 224. Taller modes wrap at 256 and place the map at a different base.

A request is accepted only while the block is idle. The result appears a fixed number of cycles later together with a one-cycle valid strobe. Video memory is read through a simple port whose data returns one cycle after the address.

Top module: `bg_pixel_fetch`

## Requirements
- R1: While reset is held and in the first cycle after it, `pix_valid`, `busy` and `vram_rd` are all 0.
- R2: A `start` seen on a clock edge with `busy` low is accepted. `pix_valid` is then high for exactly one cycle, starting 8 clock edges after the accepting edge, and `busy` is low again at that point. A `start` seen while `busy` is high is ignored: it produces no read, no strobe and no change to the pending result.
- R3: The horizontal offset is `pix_x - hscroll` modulo 256. When `hlock` is 1 and `pix_x` is below 16, the offset is `pix_x` unchanged.
- R4: The vertical sum is the 9-bit value `pix_y + vscroll`. When `vlock` is 1 and the horizontal offset is above 191, the sum is `pix_y` alone.
- R5: With `tall_mode` = 0, a vertical sum of 224 or more has 224 subtracted once, and the map base is `nt_sel << 11`.
- R6: With `tall_mode` = 1, the vertical offset is the sum modulo 256, and the map base is `({nt_sel[2:1],1'b0} << 11) | 0x700`.
- R7: The map entry address is `(base + (voff/8)*64 + (hoff/8)*2) mod 2^14`. The low byte of the entry is read at that address and the high byte at the next one.
- R8: The pattern number is entry bits 8..0. Plane k (k = 0..3) is read at `(pattern*32 + (voff mod 8)*4 + k) mod 2^14`.
- R9: Bit n of `pix_color` is bit `7 - (hoff mod 8)` of the byte read for plane n.
- R10: `pix_pal` is bit 11 of the map entry and `pix_prio` is bit 12.
- R11: `vram_rd` is high only while `busy`. Each accepted request issues exactly six reads, in the order: entry low, entry high, plane 0, plane 1, plane 2, plane 3. Read data is sampled on the second clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pixel request, taken when idle |
| pix_x | input | 8 | Screen column |
| pix_y | input | 8 | Screen line |
| hscroll | input | 8 | Horizontal scroll value (subtracted) |
| vscroll | input | 8 | Vertical scroll value (added) |
| hlock | input | 1 | Pin columns 0..15 against horizontal scroll |
| vlock | input | 1 | Pin offsets above 191 against vertical scroll |
| nt_sel | input | 3 | Tile map base select |
| tall_mode | input | 1 | 0: 192-line mode, 1: taller mode |
| vram_rd | output | 1 | Video memory read request |
| vram_addr | output | 14 | Video memory byte address |
| vram_data | input | 8 | Read data, one cycle after the address |
| busy | output | 1 | Fetch in progress |
| pix_valid | output | 1 | One-cycle result strobe |
| pix_color | output | 4 | Colour index |
| pix_pal | output | 1 | Palette select |
| pix_prio | output | 1 | Priority flag |

## Verification
The assertions rely on a few assumptions about the inputs. Video memory must answer every read with defined data on the following cycle. The coordinate, scroll and mode inputs must hold defined values whenever reset is released. A `start` arriving mid-fetch must be harmless. The bench meets these conditions with a memory model at the falling edge that returns a computed byte for every address one cycle later. It drives all inputs from reset onward and changes them only on falling edges. It also deliberately raises `start` with altered coordinates in the middle of a fetch, to show that the request is dropped.

// File: rtl/bgf_pkg.sv
// Shared constants and the fetch step encoding for the background
// pixel fetcher. Assumes 8-bit coordinates and a 14-bit byte address.
package bgf_pkg;
    localparam int BGF_COORD_W     = 8;
    localparam int BGF_VOFF_W      = BGF_COORD_W + 1;
    localparam int BGF_ADDR_W      = 14;
    localparam int BGF_NT_W        = 3;
    localparam int BGF_DATA_W      = 8;
    localparam int BGF_PLANES      = 4;
    localparam int BGF_WRAP_ROWS   = 224;
    localparam int BGF_HLOCK_COLS  = 16;
    localparam int BGF_VLOCK_LIMIT = 191;
    localparam int BGF_NT_SHIFT    = 11;
    localparam int BGF_TALL_OFS    = 'h700;

    // One step per cycle of a fetch; ordering is the read order.
    typedef enum logic [2:0] {
        ST_MAP_LO = 3'd0,
        ST_MAP_HI = 3'd1,
        ST_ENTRY  = 3'd2,
        ST_PL0    = 3'd3,
        ST_PL1    = 3'd4,
        ST_PL2    = 3'd5,
        ST_PL3    = 3'd6,
        ST_DONE   = 3'd7
    } bgf_step_e;
endpackage

// File: rtl/bgf_offset.sv
// Scroll and map-address stage. Purely combinational: turns the pixel
// coordinate and scroll state into the fine offsets inside a tile and
// the byte address of the tile map entry. Assumes VW = CW + 1.
module bgf_offset
    import bgf_pkg::*;
#(
    parameter int CW = BGF_COORD_W,
    parameter int VW = BGF_VOFF_W,
    parameter int AW = BGF_ADDR_W,
    parameter int NW = BGF_NT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    input  logic [CW-1:0] hscroll,
    input  logic [CW-1:0] vscroll,
    input  logic          hlock,
    input  logic          vlock,
    input  logic [NW-1:0] nt_sel,
    input  logic          tall,
    output logic [2:0]    hfine,
    output logic [2:0]    vfine,
    output logic [AW-1:0] map_addr
);
    localparam logic [VW-1:0] WRAP_V     = VW'(BGF_WRAP_ROWS);
    localparam logic [CW-1:0] HLOCK_X    = CW'(BGF_HLOCK_COLS);
    localparam logic [CW-1:0] VLOCK_H    = CW'(BGF_VLOCK_LIMIT);
    localparam logic [AW-1:0] TALL_OFS_A = AW'(BGF_TALL_OFS);

    logic [CW-1:0] hoff;
    logic [VW-1:0] vsum;
    logic [VW-1:0] voff;
    logic [AW-1:0] base;

    // Offsets with region locks, mode-dependent wrap and map base.
    always_comb begin
        hoff = (hlock && (x < HLOCK_X)) ? x : x - hscroll;
        vsum = (vlock && (hoff > VLOCK_H)) ? VW'(y) : VW'(y) + VW'(vscroll);
        if (tall) begin
            voff = VW'(vsum[CW-1:0]);
            base = (AW'({nt_sel[NW-1:1], 1'b0}) << BGF_NT_SHIFT) | TALL_OFS_A;
        end else begin
            voff = (vsum >= WRAP_V) ? vsum - WRAP_V : vsum;
            base = AW'(nt_sel) << BGF_NT_SHIFT;
        end
        map_addr = base + (AW'(voff >> 3) << 6) + (AW'(hoff >> 3) << 1);
        hfine    = hoff[2:0];
        vfine    = voff[2:0];
    end

    AST_TALL_VOFF_8BIT: assert property (@(posedge clk) disable iff (!rst_n)
        tall |-> (voff[VW-1] == 1'b0)); // R6
    AST_SHORT_VOFF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !tall |-> (voff <= VW'(2 * (2 ** CW - 1) - BGF_WRAP_ROWS))); // R5
endmodule

// File: rtl/bgf_pick.sv
// Plane bit picker. Gathers one bit from each bit-plane byte, taking
// the planes MSB-first so that column 0 of a tile is bit 7.
module bgf_pick
    import bgf_pkg::*;
#(
    parameter int NP = BGF_PLANES,
    parameter int DW = BGF_DATA_W
) (
    input  logic [NP-1:0][DW-1:0] planes,
    input  logic [2:0]            hsel,
    output logic [NP-1:0]         color
);
    logic [2:0] bit_idx;

    // Column within the tile maps to a descending bit index.
    always_comb bit_idx = 3'd7 - hsel;

    for (genvar n = 0; n < NP; n++) begin : g_plane
        assign color[n] = planes[n][bit_idx];
    end
endmodule

// File: rtl/bgf_seq.sv
// Fetch sequencer. Latches a request when idle and walks eight steps:
// reads the two map bytes, leaves one cycle for the entry to settle,
// then reads four plane bytes and registers the pixel. Assumes memory
// data arrives the cycle after each address.
module bgf_seq
    import bgf_pkg::*;
#(
    parameter int AW = BGF_ADDR_W,
    parameter int DW = BGF_DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [2:0]         hfine_in,
    input  logic [2:0]         vfine_in,
    input  logic [AW-1:0]      map_in,
    input  logic [DW-1:0]      vram_data,
    input  logic [3:0]         pick_color,
    output logic               vram_rd,
    output logic [AW-1:0]      vram_addr,
    output logic               busy,
    output logic [2:0][DW-1:0] pl_q,
    output logic [2:0]         hsel,
    output logic               pix_valid,
    output logic [3:0]         pix_color,
    output logic               pix_pal,
    output logic               pix_prio
);
    bgf_step_e     step;
    logic [2:0]    vrow_q;
    logic [AW-1:0] map_q;
    logic [DW-1:0] lo_q;
    logic          pat_hi_q;
    logic          pal_q;
    logic          prio_q;
    logic [1:0]    plane_idx;

    // Request latch, step counter and capture of returned bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            step      <= ST_MAP_LO;
            hsel      <= '0;
            vrow_q    <= '0;
            map_q     <= '0;
            lo_q      <= '0;
            pat_hi_q  <= 1'b0;
            pal_q     <= 1'b0;
            prio_q    <= 1'b0;
            pl_q      <= '0;
            pix_valid <= 1'b0;
            pix_color <= '0;
            pix_pal   <= 1'b0;
            pix_prio  <= 1'b0;
        end else begin
            pix_valid <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy   <= 1'b1;
                    step   <= ST_MAP_LO;
                    hsel   <= hfine_in;
                    vrow_q <= vfine_in;
                    map_q  <= map_in;
                end
            end else begin
                step <= bgf_step_e'(step + 3'd1);
                unique case (step)
                    ST_MAP_HI: lo_q <= vram_data;
                    ST_ENTRY: begin
                        pat_hi_q <= vram_data[0];
                        pal_q    <= vram_data[3];
                        prio_q   <= vram_data[4];
                    end
                    ST_PL1: pl_q[0] <= vram_data;
                    ST_PL2: pl_q[1] <= vram_data;
                    ST_PL3: pl_q[2] <= vram_data;
                    ST_DONE: begin
                        busy      <= 1'b0;
                        pix_valid <= 1'b1;
                        pix_color <= pick_color;
                        pix_pal   <= pal_q;
                        pix_prio  <= prio_q;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read request and address for the current step.
    always_comb begin
        plane_idx = 2'(3'(step) - 3'(ST_PL0));
        vram_rd   = busy && (step != ST_ENTRY) && (step != ST_DONE);
        unique case (step)
            ST_MAP_LO: vram_addr = map_q;
            ST_MAP_HI: vram_addr = map_q + AW'(1);
            default:   vram_addr = AW'({pat_hi_q, lo_q, vrow_q, plane_idx});
        endcase
    end

    AST_RD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        vram_rd |-> busy); // R11
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> !pix_valid); // R2
    AST_VALID_ENDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (!busy && $past(busy))); // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(map_q) && $stable(hsel))); // R2
endmodule

// File: rtl/bg_pixel_fetch.sv
// Top of the background pixel fetcher: scroll/address stage, fetch
// sequencer and plane bit picker. One pixel per request; assumes the
// requester waits for the strobe before the next request matters.
module bg_pixel_fetch
    import bgf_pkg::*;
#(
    parameter int CW = BGF_COORD_W,
    parameter int AW = BGF_ADDR_W,
    parameter int NW = BGF_NT_W,
    parameter int DW = BGF_DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] pix_x,
    input  logic [CW-1:0] pix_y,
    input  logic [CW-1:0] hscroll,
    input  logic [CW-1:0] vscroll,
    input  logic          hlock,
    input  logic          vlock,
    input  logic [NW-1:0] nt_sel,
    input  logic          tall_mode,
    output logic          vram_rd,
    output logic [AW-1:0] vram_addr,
    input  logic [DW-1:0] vram_data,
    output logic          busy,
    output logic          pix_valid,
    output logic [3:0]    pix_color,
    output logic          pix_pal,
    output logic          pix_prio
);
    localparam int VW = CW + 1;

    logic [2:0]         hfine;
    logic [2:0]         vfine;
    logic [AW-1:0]      map_addr;
    logic [2:0][DW-1:0] pl_q;
    logic [2:0]         hsel;
    logic [3:0]         pick_color;

    bgf_offset #(.CW(CW), .VW(VW), .AW(AW), .NW(NW)) u_offset (
        .clk(clk), .rst_n(rst_n),
        .x(pix_x), .y(pix_y), .hscroll(hscroll), .vscroll(vscroll),
        .hlock(hlock), .vlock(vlock), .nt_sel(nt_sel), .tall(tall_mode),
        .hfine(hfine), .vfine(vfine), .map_addr(map_addr)
    );

    bgf_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .hfine_in(hfine), .vfine_in(vfine), .map_in(map_addr),
        .vram_data(vram_data), .pick_color(pick_color),
        .vram_rd(vram_rd), .vram_addr(vram_addr), .busy(busy),
        .pl_q(pl_q), .hsel(hsel),
        .pix_valid(pix_valid), .pix_color(pix_color),
        .pix_pal(pix_pal), .pix_prio(pix_prio)
    );

    bgf_pick #(.NP(4), .DW(DW)) u_pick (
        .planes({vram_data, pl_q[2], pl_q[1], pl_q[0]}),
        .hsel(hsel),
        .color(pick_color)
    );
endmodule

// File: tb/sim_bg_pixel_fetch.sv
module sim_bg_pixel_fetch;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, start, hlock, vlock, tall_mode;
    logic [7:0]  pix_x, pix_y, hscroll, vscroll;
    logic [2:0]  nt_sel;
    logic        vram_rd, busy, pix_valid, pix_pal, pix_prio;
    logic [13:0] vram_addr;
    logic [7:0]  vram_data = 8'h00;
    logic [3:0]  pix_color;

    int n_tests = 0;
    int n_fail  = 0;
    int rd_cnt  = 0;
    logic [13:0] rd_log [8];
    logic        pend_vld = 1'b0;
    logic [13:0] pend_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bg_pixel_fetch u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pix_x(pix_x), .pix_y(pix_y),
        .hscroll(hscroll), .vscroll(vscroll), .hlock(hlock), .vlock(vlock),
        .nt_sel(nt_sel), .tall_mode(tall_mode), .vram_rd(vram_rd),
        .vram_addr(vram_addr), .vram_data(vram_data), .busy(busy),
        .pix_valid(pix_valid), .pix_color(pix_color), .pix_pal(pix_pal),
        .pix_prio(pix_prio)
    );

    function automatic logic [7:0] vram_fn(input logic [13:0] a);
        int v;
        v = int'(a) * 29 ^ (int'(a) >> 5) ^ 165;
        return v[7:0];
    endfunction

    // Memory model: data for an address comes one cycle later; log reads.
    always @(negedge clk) begin
        vram_data <= pend_vld ? vram_fn(pend_addr) : 8'h00;
        pend_vld  <= vram_rd;
        pend_addr <= vram_addr;
        if (vram_rd) begin
            if (rd_cnt < 8) rd_log[rd_cnt] = vram_addr;
            rd_cnt++;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic expect_px(input logic [7:0] x, y, hs, vs, input logic hl, vl,
                             input logic [2:0] nt, input logic tl,
                             output logic [5:0][13:0] ea, output logic [3:0] col,
                             output logic pal, output logic prio);
        logic [7:0] ho, lo, hi, b;
        logic [8:0] s9, vo;
        int base, m;
        logic [8:0] pat;
        ho = (hl && x < 8'd16) ? x : 8'(x - hs);
        s9 = (vl && ho > 8'd191) ? {1'b0, y} : {1'b0, y} + {1'b0, vs};
        if (tl) begin
            vo   = {1'b0, s9[7:0]};
            base = (int'({nt[2:1], 1'b0}) * 2048) | 'h700;
        end else begin
            vo   = (s9 >= 9'd224) ? s9 - 9'd224 : s9;
            base = int'(nt) * 2048;
        end
        m = base + (int'(vo) / 8) * 64 + (int'(ho) / 8) * 2;
        ea[0] = m[13:0];
        ea[1] = 14'(m + 1);
        lo = vram_fn(ea[0]);
        hi = vram_fn(ea[1]);
        pat = {hi[0], lo};
        for (int k = 0; k < 4; k++) begin
            m = int'(pat) * 32 + (int'(vo) % 8) * 4 + k;
            ea[k+2] = m[13:0];
            b = vram_fn(ea[k+2]);
            col[k] = b[7 - (int'(ho) % 8)];
        end
        pal  = hi[3];
        prio = hi[4];
    endtask

    task automatic do_pixel(input logic [7:0] x, y, hs, vs, input logic hl, vl,
                            input logic [2:0] nt, input logic tl,
                            input string tag, input bit inject);
        logic [5:0][13:0] ea;
        logic [3:0] col;
        logic pal, prio;
        int n, extra;
        bit seq_ok;
        expect_px(x, y, hs, vs, hl, vl, nt, tl, ea, col, pal, prio);
        @(negedge clk);
        pix_x = x; pix_y = y; hscroll = hs; vscroll = vs;
        hlock = hl; vlock = vl; nt_sel = nt; tall_mode = tl;
        start = 1'b1; rd_cnt = 0;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!pix_valid && n < 40) begin
            if (inject && n == 3) begin start = 1'b1; pix_x = x ^ 8'h55; pix_y = y ^ 8'h33; end
            if (inject && n == 4) begin start = 1'b0; pix_x = x; pix_y = y; end
            @(negedge clk);
            n++;
        end
        chk(n == 8, {tag, " R2 strobe latency"}, n, 8);
        chk(pix_color == col, {tag, " R9 colour index"}, int'(pix_color), int'(col));
        chk(pix_pal == pal, {tag, " R10 palette bit"}, int'(pix_pal), int'(pal));
        chk(pix_prio == prio, {tag, " R10 priority bit"}, int'(pix_prio), int'(prio));
        seq_ok = (rd_cnt == 6);
        for (int k = 0; k < 6; k++) if (rd_log[k] !== ea[k]) seq_ok = 0;
        chk(seq_ok, {tag, " R7/R8/R11 read sequence (first addr)"}, int'(rd_log[0]), int'(ea[0]));
        if (inject) begin
            extra = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (pix_valid) extra++;
            end
            chk(extra == 0 && rd_cnt == 6, {tag, " R2 start during busy ignored"}, extra * 16 + rd_cnt, 6);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        rst_n = 1'b0; start = 1'b0; hlock = 1'b0; vlock = 1'b0; tall_mode = 1'b0;
        pix_x = '0; pix_y = '0; hscroll = '0; vscroll = '0; nt_sel = '0;
        seed = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!pix_valid && !busy && !vram_rd, "R1 outputs idle in reset",
            int'({pix_valid, busy, vram_rd}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pix_valid && !busy && !vram_rd, "R1 outputs idle after reset",
            int'({pix_valid, busy, vram_rd}), 0);

        // R3: horizontal lock and its column boundary
        do_pixel(8'd5,  8'd10, 8'h30, 8'd0, 1'b1, 1'b0, 3'd1, 1'b0, "R3 locked col", 0);
        do_pixel(8'd16, 8'd10, 8'h30, 8'd0, 1'b1, 1'b0, 3'd1, 1'b0, "R3 col 16", 0);
        do_pixel(8'd5,  8'd10, 8'h30, 8'd0, 1'b0, 1'b0, 3'd1, 1'b0, "R3 unlocked", 0);
        // R4: vertical lock right of column 191
        do_pixel(8'd200, 8'd40, 8'd0, 8'h40, 1'b0, 1'b1, 3'd2, 1'b0, "R4 locked", 0);
        do_pixel(8'd191, 8'd40, 8'd0, 8'h40, 1'b0, 1'b1, 3'd2, 1'b0, "R4 hoff 191", 0);
        // R5: short mode wrap points
        do_pixel(8'd20, 8'd200, 8'd0, 8'd30,  1'b0, 1'b0, 3'd7, 1'b0, "R5 wrap", 0);
        do_pixel(8'd20, 8'd223, 8'd0, 8'd0,   1'b0, 1'b0, 3'd7, 1'b0, "R5 row 223", 0);
        do_pixel(8'd20, 8'd255, 8'd0, 8'd255, 1'b0, 1'b0, 3'd7, 1'b0, "R5 max sum", 0);
        // R6: tall mode
        do_pixel(8'd77, 8'd200, 8'd9, 8'd100, 1'b0, 1'b0, 3'd3, 1'b1, "R6 tall", 0);
        do_pixel(8'd0,  8'd255, 8'd0, 8'd1,   1'b0, 1'b0, 3'd6, 1'b1, "R6 tall edge", 0);
        // R2: request while busy
        do_pixel(8'd99, 8'd50, 8'd3, 8'd4, 1'b0, 1'b0, 3'd4, 1'b0, "R2 inject", 1);

        for (int i = 0; i < 200; i++) begin
            do_pixel(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                     ($urandom % 4) == 0, ($urandom % 4) == 0, 3'($urandom),
                     1'($urandom), "rand", 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule